// File: doc/BRIEF.md
# Redundant Result Pairing Checker

The block sits at the check stage of a core that runs one instruction stream twice, as a leading copy and a trailing copy. Each copy delivers its result tagged with the active-list slot of the instruction. The block keeps one entry per slot. Whichever copy arrives first leaves its value in the entry and marks the entry full. The copy that arrives second compares its value against the stored one and records a verdict in the slot's commit status.

The commit stage asks about its head slot every cycle. The block answers one cycle later. A slot whose verdict is still open stalls retirement. A passing slot retires and its entry is cleared. A failing slot raises a flush that names the slot, so the core can restart at that instruction, and every entry is cleared.

The full bit and the two-bit status of each entry are held in three copies. Every read takes a bitwise majority of the copies, and every write rewrites all three copies. A single upset bit therefore cannot leave a pair waiting forever. A narrow upset-injection port flips one stored copy bit so this protection can be exercised.

Top module: `pair_check_queue`

## Requirements
- R1: After a synchronous reset, every entry is empty with status waiting (00), and retire_ok, head_stall, flush_valid and flush_slot are all 0.
- R2: A result from either copy that reaches an empty entry whose status is waiting stores its data and marks the entry full. The status stays waiting.
- R3: A result that reaches a full entry whose status is waiting is compared with the stored data. Equal data sets the status to pass (01) and unequal data sets it to fail (10). In both cases the entry becomes empty.
- R4: When both copies write the same slot in the same cycle, their two data words are compared directly. The status becomes pass or fail, nothing is stored, and the entry stays empty.
- R5: A head query (head_valid with head_slot) on a slot whose voted status is 00 raises head_stall in the next cycle and does not raise retire_ok.
- R6: A head query on a slot whose voted status is 01 raises retire_ok in the next cycle. In the same edge the entry returns to empty and waiting, and this clear overrides any write to that slot in that cycle.
- R7: A head query on a slot whose voted status has bit 1 set raises flush_valid in the next cycle, with flush_slot equal to the queried slot. All entries are cleared in that same edge, and all writes and upsets of that cycle are dropped. flush_slot holds its value until the next flush.
- R8: A write to an entry whose voted status is not waiting is ignored.
- R9: Each entry word is {status[1:0], full} and is kept in three copies. Every read uses the bitwise majority of the copies, and every write or clear sets all three copies. upset_en flips bit upset_bit (0 is full, 1 is status bit 0, 2 is status bit 1) of copy upset_copy (0 to 2) in slot upset_slot. The flip is lost if the same slot is written or cleared in that cycle. Values 3 of upset_copy or upset_bit do nothing.
- R10: Writes from the two copies to different slots in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_valid | input | 1 | Leading copy delivers a result |
| lead_slot | input | SLOT_W | Slot of the leading result |
| lead_data | input | DATA_W | Leading result value |
| trail_valid | input | 1 | Trailing copy delivers a result |
| trail_slot | input | SLOT_W | Slot of the trailing result |
| trail_data | input | DATA_W | Trailing result value |
| head_valid | input | 1 | Commit stage queries its head slot |
| head_slot | input | SLOT_W | Slot at the commit head |
| upset_en | input | 1 | Flip one stored copy bit |
| upset_slot | input | SLOT_W | Slot of the flipped bit |
| upset_copy | input | 2 | Copy to flip (0 to 2) |
| upset_bit | input | 2 | Bit to flip: 0 is full, 1 and 2 are status bits |
| retire_ok | output | 1 | Queried head passed and retires |
| head_stall | output | 1 | Queried head is not yet checked |
| flush_valid | output | 1 | Queried head failed, so flush and restart |
| flush_slot | output | SLOT_W | Slot to restart at |

## Verification
Every head answer (retire_ok, head_stall, flush_valid, flush_slot) is due in the cycle after the edge that samples the query. A result write changes the entry in that same edge, so a query issued in the following cycle sees it, and its answer appears one cycle later again. The bench updates a behavioural model at each rising edge and compares all four outputs 1 ns after that edge, so each comparison sees exactly one edge's worth of change. Corner cases include same-cycle same-slot arrival, a clear that collides with a write, writes dropped during a flush, and single and double copy upsets.

// File: rtl/pcq_pkg.sv
package pcq_pkg;
  // entry word layout: {status[1:0], full}
  localparam int unsigned WORD_W   = 3;
  localparam logic [1:0]  ST_WAIT  = 2'b00;
  localparam logic [1:0]  ST_PASS  = 2'b01;
  localparam logic [1:0]  ST_FAIL  = 2'b10;
  localparam int unsigned COPIES   = 3;
endpackage

// File: rtl/pcq_tmr_store.sv
module pcq_tmr_store #(
  parameter  int unsigned ENTRIES = 16,
  parameter  int unsigned W       = 3,
  localparam int unsigned IDX_W   = $clog2(ENTRIES),
  localparam int unsigned SEL_W   = $clog2(W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_all,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic                 a_en,
  input  logic [IDX_W-1:0]     a_idx,
  input  logic [W-1:0]         a_val,
  input  logic                 b_en,
  input  logic [IDX_W-1:0]     b_idx,
  input  logic [W-1:0]         b_val,
  input  logic                 upset_en,
  input  logic [IDX_W-1:0]     upset_idx,
  input  logic [1:0]           upset_copy,
  input  logic [SEL_W-1:0]     upset_bit,
  output logic [ENTRIES*W-1:0] voted
);
  logic upset_legal;
  assign upset_legal = upset_en && (32'(upset_bit) < W);

  genvar c;
  generate
    for (c = 0; c < pcq_pkg::COPIES; c++) begin : g_copy
      logic [W-1:0] mem_q [ENTRIES];
      always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
          if (rst || clr_all)
            mem_q[e] <= '0;
          else if (clr_en && clr_idx == IDX_W'(e))
            mem_q[e] <= '0;
          else if (a_en && a_idx == IDX_W'(e))
            mem_q[e] <= a_val;
          else if (b_en && b_idx == IDX_W'(e))
            mem_q[e] <= b_val;
          else if (upset_legal && upset_idx == IDX_W'(e) && upset_copy == 2'(c))
            mem_q[e] <= mem_q[e] ^ (W'(1) << upset_bit);
        end
      end
    end
  endgenerate

  genvar e;
  generate
    for (e = 0; e < ENTRIES; e++) begin : g_vote
      assign voted[e*W +: W] = (g_copy[0].mem_q[e] & g_copy[1].mem_q[e]) |
                               (g_copy[0].mem_q[e] & g_copy[2].mem_q[e]) |
                               (g_copy[1].mem_q[e] & g_copy[2].mem_q[e]);
    end
  endgenerate

  logic [IDX_W-1:0] clr_idx_q;
  always_ff @(posedge clk) clr_idx_q <= clr_idx;

  // R7
  wipe_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> voted == '0);

  // R6
  slot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !clr_all) |=> voted[clr_idx_q*W +: W] == '0);
endmodule

// File: rtl/pcq_value_regs.sv
module pcq_value_regs #(
  parameter  int unsigned ENTRIES = 16,
  parameter  int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_we,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_data,
  output logic [DATA_W-1:0] a_rd,
  output logic [DATA_W-1:0] b_rd
);
  logic [DATA_W-1:0] val_q [ENTRIES];

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (a_we && a_idx == IDX_W'(e))
        val_q[e] <= a_data;
      else if (b_we && b_idx == IDX_W'(e))
        val_q[e] <= b_data;
    end
  end

  assign a_rd = val_q[a_idx];
  assign b_rd = val_q[b_idx];
endmodule

// File: rtl/pair_check_queue.sv
module pair_check_queue #(
  parameter  int unsigned DATA_W  = 32,
  parameter  int unsigned ENTRIES = 16,
  localparam int unsigned SLOT_W  = $clog2(ENTRIES),
  localparam int unsigned WORD_W  = pcq_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lead_valid,
  input  logic [SLOT_W-1:0] lead_slot,
  input  logic [DATA_W-1:0] lead_data,
  input  logic              trail_valid,
  input  logic [SLOT_W-1:0] trail_slot,
  input  logic [DATA_W-1:0] trail_data,
  input  logic              head_valid,
  input  logic [SLOT_W-1:0] head_slot,
  input  logic              upset_en,
  input  logic [SLOT_W-1:0] upset_slot,
  input  logic [1:0]        upset_copy,
  input  logic [1:0]        upset_bit,
  output logic              retire_ok,
  output logic              head_stall,
  output logic              flush_valid,
  output logic [SLOT_W-1:0] flush_slot
);
  import pcq_pkg::*;

  logic [ENTRIES*WORD_W-1:0] word_vec;
  logic [WORD_W-1:0] lead_word, trail_word, head_word;
  logic [DATA_W-1:0] lead_stored, trail_stored;
  logic same_slot, lead_open, trail_open;
  logic head_pass, head_fail, head_wait, retire_now, flush_now;
  logic a_en, b_en, a_dep, b_dep;
  logic [WORD_W-1:0] a_val, b_val;

  assign lead_word  = word_vec[lead_slot*WORD_W  +: WORD_W];
  assign trail_word = word_vec[trail_slot*WORD_W +: WORD_W];
  assign head_word  = word_vec[head_slot*WORD_W  +: WORD_W];

  assign head_pass  = head_word[2:1] == ST_PASS;
  assign head_wait  = head_word[2:1] == ST_WAIT;
  assign head_fail  = head_word[2];
  assign retire_now = head_valid && head_pass;
  assign flush_now  = head_valid && head_fail;

  assign same_slot  = lead_valid && trail_valid && (lead_slot == trail_slot);
  assign lead_open  = lead_word[2:1]  == ST_WAIT;
  assign trail_open = trail_word[2:1] == ST_WAIT;

  always_comb begin
    a_en  = lead_valid && lead_open && !flush_now;
    a_dep = 1'b0;
    if (same_slot)
      a_val = {(lead_data == trail_data) ? ST_PASS : ST_FAIL, 1'b0};
    else if (lead_word[0])
      a_val = {(lead_data == lead_stored) ? ST_PASS : ST_FAIL, 1'b0};
    else begin
      a_val = {ST_WAIT, 1'b1};
      a_dep = a_en;
    end
  end

  always_comb begin
    b_en  = trail_valid && trail_open && !same_slot && !flush_now;
    b_dep = 1'b0;
    if (trail_word[0])
      b_val = {(trail_data == trail_stored) ? ST_PASS : ST_FAIL, 1'b0};
    else begin
      b_val = {ST_WAIT, 1'b1};
      b_dep = b_en;
    end
  end

  pcq_tmr_store #(.ENTRIES(ENTRIES), .W(WORD_W)) u_status (
    .clk        (clk),
    .rst        (rst),
    .clr_all    (flush_now),
    .clr_en     (retire_now),
    .clr_idx    (head_slot),
    .a_en       (a_en),
    .a_idx      (lead_slot),
    .a_val      (a_val),
    .b_en       (b_en),
    .b_idx      (trail_slot),
    .b_val      (b_val),
    .upset_en   (upset_en),
    .upset_idx  (upset_slot),
    .upset_copy (upset_copy),
    .upset_bit  (upset_bit),
    .voted      (word_vec)
  );

  pcq_value_regs #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_values (
    .clk    (clk),
    .a_we   (a_dep),
    .a_idx  (lead_slot),
    .a_data (lead_data),
    .b_we   (b_dep),
    .b_idx  (trail_slot),
    .b_data (trail_data),
    .a_rd   (lead_stored),
    .b_rd   (trail_stored)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      retire_ok   <= 1'b0;
      head_stall  <= 1'b0;
      flush_valid <= 1'b0;
      flush_slot  <= '0;
    end else begin
      retire_ok   <= retire_now;
      head_stall  <= head_valid && head_wait;
      flush_valid <= flush_now;
      if (flush_now) flush_slot <= head_slot;
    end
  end

  // R5
  answer_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({retire_ok, head_stall, flush_valid}));

  // R7
  flush_slot_chk: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> flush_slot == $past(head_slot));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> word_vec == '0);

  // R6
  retire_query_chk: assert property (@(posedge clk) disable iff (rst)
    retire_ok |-> $past(head_valid));
endmodule

// File: tb/pair_check_queue_bench.sv
`timescale 1ns/1ps
module pair_check_queue_bench;
  localparam int DW = 32;
  localparam int NE = 16;

  logic clk = 1'b0;
  logic rst;
  logic lead_valid, trail_valid, head_valid, upset_en;
  logic [3:0] lead_slot, trail_slot, head_slot, upset_slot;
  logic [DW-1:0] lead_data, trail_data;
  logic [1:0] upset_copy, upset_bit;
  logic retire_ok, head_stall, flush_valid;
  logic [3:0] flush_slot;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model: three copies of each {status, full} word, plus stored data
  int unsigned cp [3][NE];
  logic [DW-1:0] dv [NE];
  logic [3:0] exp_fslot;

  always #2.5 clk = ~clk;

  pair_check_queue #(.DATA_W(DW), .ENTRIES(NE)) u_pair_check_queue (
    .clk(clk), .rst(rst),
    .lead_valid(lead_valid), .lead_slot(lead_slot), .lead_data(lead_data),
    .trail_valid(trail_valid), .trail_slot(trail_slot), .trail_data(trail_data),
    .head_valid(head_valid), .head_slot(head_slot),
    .upset_en(upset_en), .upset_slot(upset_slot),
    .upset_copy(upset_copy), .upset_bit(upset_bit),
    .retire_ok(retire_ok), .head_stall(head_stall),
    .flush_valid(flush_valid), .flush_slot(flush_slot)
  );

  function automatic int unsigned maj(int unsigned a, int unsigned b, int unsigned c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic idle_in();
    lead_valid = 0; trail_valid = 0; head_valid = 0; upset_en = 0;
    lead_slot = 0; trail_slot = 0; head_slot = 0; upset_slot = 0;
    lead_data = 0; trail_data = 0; upset_copy = 0; upset_bit = 0;
  endtask

  task automatic model_reset();
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < NE; s++) cp[c][s] = 0;
    exp_fslot = 0;
  endtask

  // one clock: predict, advance, compare
  task automatic tick(string tag);
    int unsigned w [NE];
    int unsigned ncp [3][NE];
    logic [DW-1:0] ndv [NE];
    int unsigned hs, word;
    bit e_ret, e_st, e_fl, same;
    for (int s = 0; s < NE; s++) w[s] = maj(cp[0][s], cp[1][s], cp[2][s]);
    ncp = cp; ndv = dv;
    hs = (w[head_slot] >> 1) & 3;
    e_ret = head_valid && hs == 1;
    e_st  = head_valid && hs == 0;
    e_fl  = head_valid && hs[1];
    if (upset_en && upset_copy < 3 && upset_bit < 3)
      ncp[upset_copy][upset_slot] = ncp[upset_copy][upset_slot] ^ (1 << upset_bit);
    same = lead_valid && trail_valid && lead_slot == trail_slot;
    if (!e_fl) begin
      if (lead_valid && (w[lead_slot] >> 1) == 0) begin
        if (same) word = (lead_data == trail_data) ? 2 : 4;
        else if (w[lead_slot] & 1) word = (lead_data == dv[lead_slot]) ? 2 : 4;
        else begin word = 1; ndv[lead_slot] = lead_data; end
        for (int c = 0; c < 3; c++) ncp[c][lead_slot] = word;
      end
      if (trail_valid && !same && (w[trail_slot] >> 1) == 0) begin
        if (w[trail_slot] & 1) word = (trail_data == dv[trail_slot]) ? 2 : 4;
        else begin word = 1; ndv[trail_slot] = trail_data; end
        for (int c = 0; c < 3; c++) ncp[c][trail_slot] = word;
      end
    end
    if (e_ret) for (int c = 0; c < 3; c++) ncp[c][head_slot] = 0;
    if (e_fl) begin
      for (int c = 0; c < 3; c++)
        for (int s = 0; s < NE; s++) ncp[c][s] = 0;
      exp_fslot = head_slot;
    end
    @(posedge clk);
    #1;
    cp = ncp; dv = ndv;
    checks++;
    if (retire_ok !== e_ret || head_stall !== e_st || flush_valid !== e_fl ||
        flush_slot !== exp_fslot) begin
      errors++;
      $display("FAIL %s: retire/stall/flush/slot actual=%b%b%b/%0d expected=%b%b%b/%0d",
               tag, retire_ok, head_stall, flush_valid, flush_slot,
               e_ret, e_st, e_fl, exp_fslot);
    end
  endtask

  task automatic query(int s, string tag);
    idle_in(); head_valid = 1; head_slot = 4'(s); tick(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_in(); model_reset();
    for (int i = 0; i < NE; i++) dv[i] = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    checks++;
    if (retire_ok !== 0 || head_stall !== 0 || flush_valid !== 0 || flush_slot !== 0) begin
      errors++;
      $display("FAIL R1: outputs actual=%b%b%b/%0d expected=000/0",
               retire_ok, head_stall, flush_valid, flush_slot);
    end
    for (int s = 0; s < NE; s += 5) query(s, "R1 empty waits");

    // R2 lead first, R3 trail pairs equal, R6 retire then clear
    idle_in(); lead_valid = 1; lead_slot = 2; lead_data = 32'hA5A5_0001; tick("R2 deposit");
    query(2, "R2 still waiting");
    idle_in(); trail_valid = 1; trail_slot = 2; trail_data = 32'hA5A5_0001; tick("R3 pair");
    query(2, "R6 retire");
    query(2, "R6 cleared");

    // R3 trail first then mismatching lead, R7 flush
    idle_in(); trail_valid = 1; trail_slot = 3; trail_data = 32'h1234; tick("R2 trail first");
    idle_in(); lead_valid = 1; lead_slot = 3; lead_data = 32'h1235; tick("R3 mismatch");
    query(3, "R7 flush");
    query(3, "R7 all cleared");

    // R4 same cycle same slot, equal and unequal
    idle_in(); lead_valid = 1; trail_valid = 1; lead_slot = 4; trail_slot = 4;
    lead_data = 77; trail_data = 77; tick("R4 equal");
    query(4, "R4 retire");
    idle_in(); lead_valid = 1; trail_valid = 1; lead_slot = 5; trail_slot = 5;
    lead_data = 77; trail_data = 78; tick("R4 unequal");
    query(5, "R4 flush");

    // R10 two slots in one cycle
    idle_in(); lead_valid = 1; lead_slot = 6; lead_data = 10;
    trail_valid = 1; trail_slot = 7; trail_data = 20; tick("R10 both deposit");
    idle_in(); lead_valid = 1; lead_slot = 7; lead_data = 20;
    trail_valid = 1; trail_slot = 6; trail_data = 10; tick("R10 both compare");
    query(6, "R10 slot6 retire");
    query(7, "R10 slot7 retire");

    // R8 write to checked entry ignored
    idle_in(); lead_valid = 1; trail_valid = 1; lead_slot = 8; trail_slot = 8;
    lead_data = 5; trail_data = 5; tick("R8 setup");
    idle_in(); lead_valid = 1; lead_slot = 8; lead_data = 99; tick("R8 late lead");
    idle_in(); trail_valid = 1; trail_slot = 8; trail_data = 98; tick("R8 late trail");
    query(8, "R8 still retires");

    // R6 clear beats a write to the same slot
    idle_in(); lead_valid = 1; trail_valid = 1; lead_slot = 9; trail_slot = 9;
    lead_data = 1; trail_data = 1; tick("R6 setup");
    idle_in(); head_valid = 1; head_slot = 9; lead_valid = 1; lead_slot = 9; lead_data = 3;
    tick("R6 retire with write");
    query(9, "R6 clear won");

    // R7 writes dropped during flush
    idle_in(); lead_valid = 1; trail_valid = 1; lead_slot = 10; trail_slot = 10;
    lead_data = 1; trail_data = 2; tick("R7 setup");
    idle_in(); head_valid = 1; head_slot = 10; lead_valid = 1; lead_slot = 11; lead_data = 4;
    tick("R7 flush with write");
    idle_in(); trail_valid = 1; trail_slot = 11; trail_data = 9; tick("R7 trail deposits");
    query(11, "R7 write was dropped");

    // R9 single upset on full bit is masked
    idle_in(); lead_valid = 1; lead_slot = 12; lead_data = 42; tick("R9 deposit");
    idle_in(); upset_en = 1; upset_slot = 12; upset_copy = 0; upset_bit = 0; tick("R9 upset full");
    idle_in(); trail_valid = 1; trail_slot = 12; trail_data = 42; tick("R9 pair completes");
    query(12, "R9 retire");
    // R9 double upset on status bit 0 flips the vote to pass
    idle_in(); upset_en = 1; upset_slot = 13; upset_copy = 0; upset_bit = 1; tick("R9 upset a");
    query(13, "R9 one copy masked");
    idle_in(); upset_en = 1; upset_slot = 13; upset_copy = 2; upset_bit = 1; tick("R9 upset b");
    query(13, "R9 majority pass");
    // R9 copy value 3 does nothing
    idle_in(); upset_en = 1; upset_slot = 14; upset_copy = 3; upset_bit = 2; tick("R9 copy3");
    idle_in(); upset_en = 1; upset_slot = 14; upset_copy = 1; upset_bit = 2; tick("R9 msb a");
    query(14, "R9 msb masked");

    // mixed traffic against the model (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 3000; i++) begin
      idle_in();
      lead_valid  = ($urandom % 3) != 0;
      lead_slot   = 4'($urandom);
      lead_data   = 32'($urandom % 4);
      trail_valid = ($urandom % 3) != 0;
      trail_slot  = 4'($urandom);
      trail_data  = 32'($urandom % 4);
      head_valid  = ($urandom % 2) != 0;
      head_slot   = 4'($urandom);
      upset_en    = ($urandom % 8) == 0;
      upset_slot  = 4'($urandom);
      upset_copy  = 2'($urandom);
      upset_bit   = 2'($urandom);
      tick("R3 R7 R9 mixed traffic");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule